// File: doc/BRIEF.md
# Register tag redirection table

This block holds a handful of register tag entries that a group prefix loads before the instructions of the group run. Each entry names an architectural register (a 5-bit number plus an integer/floating-point class bit) and says what becomes of an operand that uses it. The entry can mark the operand as a vector, give it an element-width override code, and send it to any index in a 128-register space. The decode stage presents the two source operands and the destination operand of each scalar or compressed instruction on three independent lookup ports. Each port returns its result in the same cycle.

A compressed instruction's 3-bit register field is looked up as register 8 plus that field, so a tag can lift one of these narrow operands into the full wide register space. Prefixed 48-bit and 64-bit formats do not use the table: while the bypass input is high, every port reports a miss. Once the group ends, the clear input empties the table. Vector length and sub-vector state are held elsewhere and are not touched by the clear.

Top module: `regtag_table`

## Requirements
- R1: After reset no entry is valid, so every lookup port reports a miss.
- R2: When the write enable is high and clear is low, the entry at the write index (0 to 3) is loaded and marked valid on that clock edge. Lookups see it from the next cycle on.
- R3: A lookup matches an entry only when the entry is valid, its 5-bit key equals the operand's register number and its class bit equals the operand's class (1 = integer, 0 = floating point).
- R4: On a hit the port drives hit=1, and its isvec, element-width code (2 bits) and 7-bit redirected index come from the matching entry.
- R5: On a miss the port drives hit=0, isvec=0, element-width code 0 and an index equal to the operand's register number zero-extended to 7 bits.
- R6: When several entries match, the entry with the lowest index supplies the result.
- R7: When a port's compressed flag is high, its lookup key is 8 plus the low 3 bits of its register input, which covers registers 8 to 15.
- R8: While the bypass input is high, all three ports report a miss as in R5, whatever the table holds.
- R9: A clear invalidates all entries on the clock edge where it is high. Clear takes priority over a write in the same cycle.
- R10: The rs1, rs2 and rd ports look up independently and in parallel against the same entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | End of group: empty the table |
| wr_en_i | input | 1 | Load one entry |
| wr_idx_i | input | 2 | Slot to load |
| wr_is_int_i | input | 1 | Class of the new entry (1 integer, 0 float) |
| wr_isvec_i | input | 1 | New entry marks its operand as vector |
| wr_ew_i | input | 2 | Element-width override code of the new entry |
| wr_key_i | input | 5 | Architectural register number matched by the new entry |
| wr_tgt_i | input | 7 | Redirected register index of the new entry |
| bypass_i | input | 1 | Current opcode is a prefixed long format; force misses |
| rs1_cmp_i | input | 1 | rs1 comes from a 3-bit compressed field |
| rs1_reg_i | input | 5 | rs1 register number |
| rs1_is_int_i | input | 1 | rs1 class |
| rs1_hit_o | output | 1 | rs1 matched an entry |
| rs1_isvec_o | output | 1 | rs1 is a vector operand |
| rs1_ew_o | output | 2 | rs1 element-width code |
| rs1_idx_o | output | 7 | rs1 redirected index |
| rs2_cmp_i | input | 1 | rs2 comes from a 3-bit compressed field |
| rs2_reg_i | input | 5 | rs2 register number |
| rs2_is_int_i | input | 1 | rs2 class |
| rs2_hit_o | output | 1 | rs2 matched an entry |
| rs2_isvec_o | output | 1 | rs2 is a vector operand |
| rs2_ew_o | output | 2 | rs2 element-width code |
| rs2_idx_o | output | 7 | rs2 redirected index |
| rd_cmp_i | input | 1 | rd comes from a 3-bit compressed field |
| rd_reg_i | input | 5 | rd register number |
| rd_is_int_i | input | 1 | rd class |
| rd_hit_o | output | 1 | rd matched an entry |
| rd_isvec_o | output | 1 | rd is a vector operand |
| rd_ew_o | output | 2 | rd element-width code |
| rd_idx_o | output | 7 | rd redirected index |

## Verification
Lookup results have no delay: they follow the operand inputs and the bypass input in the same cycle. Writes and clears take effect only at the clock edge where they are presented. The bench applies each stimulus just after a falling edge and lets one rising edge pass. It updates its own table model on that same rising edge and compares all three ports at the next falling edge. Each comparison therefore sees exactly the entry state that the rising edge produced, combined with the operand inputs that were held across it.

// File: rtl/regtag_pkg.sv
package regtag_pkg;
  parameter int unsigned ARCH_W = 5;
  parameter int unsigned PHYS_W = 7;
  parameter int unsigned EW_W   = 2;
  parameter int unsigned NARROW_BASE = 8;

  typedef struct packed {
    logic              valid;
    logic              is_int;
    logic              isvec;
    logic [EW_W-1:0]   ew;
    logic [ARCH_W-1:0] key;
    logic [PHYS_W-1:0] tgt;
  } tag_entry_t;

  // Key formed from an operand field; narrow fields address registers 8..15
  function automatic logic [ARCH_W-1:0] form_key(input logic cmp,
                                                 input logic [ARCH_W-1:0] field);
    logic [ARCH_W-1:0] k;
    if (cmp) k = ARCH_W'(NARROW_BASE) | ARCH_W'(field[2:0]);
    else     k = field;
    return k;
  endfunction

  // Index used when nothing redirects the operand
  function automatic logic [PHYS_W-1:0] plain_index(input logic [ARCH_W-1:0] k);
    return PHYS_W'(k);
  endfunction
endpackage

// File: rtl/regtag_store.sv
module regtag_store
  import regtag_pkg::*;
#(
  parameter int unsigned N = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  tag_entry_t       wr_entry_i,
  output tag_entry_t       entries_o [N]
);
  tag_entry_t tbl [N];
  logic [N-1:0] valid_vec;
  logic         load_ev;

  assign load_ev = wr_en_i && !clr_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      for (int i = 0; i < N; i++) tbl[i] <= '0;
    end else if (wr_en_i) begin
      tbl[wr_idx_i]       <= wr_entry_i;
      tbl[wr_idx_i].valid <= 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign entries_o[g] = tbl[g];
    assign valid_vec[g] = tbl[g].valid;
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (valid_vec == '0)); // R9
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> valid_vec[$past(wr_idx_i)]); // R2
  AST_WRITE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (entries_o[$past(wr_idx_i)].key == $past(wr_entry_i.key))); // R2
endmodule

// File: rtl/regtag_lookup.sv
module regtag_lookup
  import regtag_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tag_entry_t        entries_i [N],
  input  logic              bypass_i,
  input  logic              cmp_i,
  input  logic [ARCH_W-1:0] reg_i,
  input  logic              is_int_i,
  output logic              hit_o,
  output logic              isvec_o,
  output logic [EW_W-1:0]   ew_o,
  output logic [PHYS_W-1:0] idx_o
);
  logic [ARCH_W-1:0] key;
  logic [N-1:0]      match_vec;
  logic [N-1:0]      grant_vec;
  logic              found;
  tag_entry_t        sel;

  assign key = form_key(cmp_i, reg_i);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = entries_i[g].valid && !bypass_i &&
                          (entries_i[g].is_int == is_int_i) &&
                          (entries_i[g].key == key);
  end

  always_comb begin
    grant_vec = '0;
    found     = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i] && !found) begin
        grant_vec[i] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_vec[i]) sel = entries_i[i];
    end
  end

  always_comb begin
    hit_o = found;
    if (found) begin
      isvec_o = sel.isvec;
      ew_o    = sel.ew;
      idx_o   = sel.tgt;
    end else begin
      isvec_o = 1'b0;
      ew_o    = '0;
      idx_o   = plain_index(key);
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec)); // R6
  AST_MISS_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (!isvec_o && ew_o == '0 && idx_o == PHYS_W'(key))); // R5
  AST_BYPASS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_i |-> !hit_o); // R8

  for (genvar g = 1; g < N; g++) begin : g_prio
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vec[g] |-> (match_vec[g-1:0] == '0)); // R6
  end
endmodule

// File: rtl/regtag_table.sv
module regtag_table
  import regtag_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_is_int_i,
  input  logic              wr_isvec_i,
  input  logic [EW_W-1:0]   wr_ew_i,
  input  logic [ARCH_W-1:0] wr_key_i,
  input  logic [PHYS_W-1:0] wr_tgt_i,
  input  logic              bypass_i,
  input  logic              rs1_cmp_i,
  input  logic [ARCH_W-1:0] rs1_reg_i,
  input  logic              rs1_is_int_i,
  output logic              rs1_hit_o,
  output logic              rs1_isvec_o,
  output logic [EW_W-1:0]   rs1_ew_o,
  output logic [PHYS_W-1:0] rs1_idx_o,
  input  logic              rs2_cmp_i,
  input  logic [ARCH_W-1:0] rs2_reg_i,
  input  logic              rs2_is_int_i,
  output logic              rs2_hit_o,
  output logic              rs2_isvec_o,
  output logic [EW_W-1:0]   rs2_ew_o,
  output logic [PHYS_W-1:0] rs2_idx_o,
  input  logic              rd_cmp_i,
  input  logic [ARCH_W-1:0] rd_reg_i,
  input  logic              rd_is_int_i,
  output logic              rd_hit_o,
  output logic              rd_isvec_o,
  output logic [EW_W-1:0]   rd_ew_o,
  output logic [PHYS_W-1:0] rd_idx_o
);
  localparam int unsigned PORTS = 3;

  tag_entry_t        wr_entry;
  tag_entry_t        entries [NUM_ENTRIES];
  logic              p_cmp   [PORTS];
  logic [ARCH_W-1:0] p_reg   [PORTS];
  logic              p_int   [PORTS];
  logic              p_hit   [PORTS];
  logic              p_vec   [PORTS];
  logic [EW_W-1:0]   p_ew    [PORTS];
  logic [PHYS_W-1:0] p_idx   [PORTS];

  always_comb begin
    wr_entry        = '0;
    wr_entry.valid  = 1'b1;
    wr_entry.is_int = wr_is_int_i;
    wr_entry.isvec  = wr_isvec_i;
    wr_entry.ew     = wr_ew_i;
    wr_entry.key    = wr_key_i;
    wr_entry.tgt    = wr_tgt_i;
  end

  regtag_store #(.N(NUM_ENTRIES)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_entry_i (wr_entry),
    .entries_o  (entries)
  );

  assign p_cmp[0] = rs1_cmp_i; assign p_reg[0] = rs1_reg_i; assign p_int[0] = rs1_is_int_i;
  assign p_cmp[1] = rs2_cmp_i; assign p_reg[1] = rs2_reg_i; assign p_int[1] = rs2_is_int_i;
  assign p_cmp[2] = rd_cmp_i;  assign p_reg[2] = rd_reg_i;  assign p_int[2] = rd_is_int_i;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    regtag_lookup #(.N(NUM_ENTRIES)) u_look (
      .clk       (clk),
      .rst_n     (rst_n),
      .entries_i (entries),
      .bypass_i  (bypass_i),
      .cmp_i     (p_cmp[p]),
      .reg_i     (p_reg[p]),
      .is_int_i  (p_int[p]),
      .hit_o     (p_hit[p]),
      .isvec_o   (p_vec[p]),
      .ew_o      (p_ew[p]),
      .idx_o     (p_idx[p])
    );
  end

  assign rs1_hit_o = p_hit[0]; assign rs1_isvec_o = p_vec[0];
  assign rs1_ew_o  = p_ew[0];  assign rs1_idx_o   = p_idx[0];
  assign rs2_hit_o = p_hit[1]; assign rs2_isvec_o = p_vec[1];
  assign rs2_ew_o  = p_ew[1];  assign rs2_idx_o   = p_idx[1];
  assign rd_hit_o  = p_hit[2]; assign rd_isvec_o  = p_vec[2];
  assign rd_ew_o   = p_ew[2];  assign rd_idx_o    = p_idx[2];

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> !(rs1_hit_o || rs2_hit_o || rd_hit_o)); // R1
  AST_SAME_OPERAND_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (rs1_reg_i == rs2_reg_i && rs1_cmp_i == rs2_cmp_i && rs1_is_int_i == rs2_is_int_i)
      |-> (rs1_hit_o == rs2_hit_o && rs1_idx_o == rs2_idx_o)); // R10
endmodule

// File: tb/tb_regtag_table.sv
module tb_regtag_table;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic       clr, wr_en, wr_int, wr_vec, bypass;
  logic [1:0] wr_idx, wr_ew;
  logic [4:0] wr_key;
  logic [6:0] wr_tgt;
  logic       c_cmp [3];
  logic [4:0] c_reg [3];
  logic       c_int [3];
  logic       o_hit [3];
  logic       o_vec [3];
  logic [1:0] o_ew  [3];
  logic [6:0] o_idx [3];

  regtag_table dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_is_int_i(wr_int), .wr_isvec_i(wr_vec), .wr_ew_i(wr_ew), .wr_key_i(wr_key),
    .wr_tgt_i(wr_tgt), .bypass_i(bypass),
    .rs1_cmp_i(c_cmp[0]), .rs1_reg_i(c_reg[0]), .rs1_is_int_i(c_int[0]),
    .rs1_hit_o(o_hit[0]), .rs1_isvec_o(o_vec[0]), .rs1_ew_o(o_ew[0]), .rs1_idx_o(o_idx[0]),
    .rs2_cmp_i(c_cmp[1]), .rs2_reg_i(c_reg[1]), .rs2_is_int_i(c_int[1]),
    .rs2_hit_o(o_hit[1]), .rs2_isvec_o(o_vec[1]), .rs2_ew_o(o_ew[1]), .rs2_idx_o(o_idx[1]),
    .rd_cmp_i(c_cmp[2]), .rd_reg_i(c_reg[2]), .rd_is_int_i(c_int[2]),
    .rd_hit_o(o_hit[2]), .rd_isvec_o(o_vec[2]), .rd_ew_o(o_ew[2]), .rd_idx_o(o_idx[2])
  );

  // Behavioural model of the table
  bit m_v [4]; bit m_int [4]; bit m_vec [4];
  int m_ew [4]; int m_key [4]; int m_tgt [4];
  int checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      foreach (m_v[i]) m_v[i] = 0;
    end else if (wr_en) begin
      m_v[wr_idx] = 1; m_int[wr_idx] = wr_int; m_vec[wr_idx] = wr_vec;
      m_ew[wr_idx] = wr_ew; m_key[wr_idx] = wr_key; m_tgt[wr_idx] = wr_tgt;
    end
  end

  // Returns {hit, isvec, ew[1:0], idx[6:0]}; number of matches in nm
  function automatic logic [10:0] ref_look(input bit cmp, input int r, input bit isint,
                                           output int nm);
    int k = cmp ? (8 + (r % 8)) : r;
    logic [10:0] res = {1'b0, 1'b0, 2'b00, 7'(k)};
    nm = 0;
    if (bypass) return res;
    for (int i = 3; i >= 0; i--) begin
      if (m_v[i] && m_int[i] == isint && m_key[i] == k) begin
        res = {1'b1, m_vec[i], 2'(m_ew[i]), 7'(m_tgt[i])};
        nm++;
      end
    end
    return res;
  endfunction

  task automatic check_all(input string tag);
    for (int p = 0; p < 3; p++) begin
      int nm;
      logic [10:0] exp = ref_look(c_cmp[p], c_reg[p], c_int[p], nm);
      logic [10:0] act = {o_hit[p], o_vec[p], o_ew[p], o_idx[p]};
      string t = tag;
      if (t == "") begin
        if (bypass) t = "R8";
        else if (nm > 1) t = "R6";
        else if (nm == 1) t = (c_cmp[p] ? "R7" : "R4");
        else t = "R5";
      end
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s port %0d: actual %h expected %h", t, p, act, exp);
      end
    end
  endtask

  task automatic idle_inputs();
    clr = 0; wr_en = 0; wr_idx = 0; wr_int = 0; wr_vec = 0; wr_ew = 0;
    wr_key = 0; wr_tgt = 0; bypass = 0;
    for (int p = 0; p < 3; p++) begin c_cmp[p] = 0; c_reg[p] = 0; c_int[p] = 0; end
  endtask

  task automatic step(input string tag);
    @(posedge clk); @(negedge clk);
    check_all(tag);
  endtask

  task automatic put(input int idx, input bit isint, input bit vec, input int ew,
                     input int key, input int tgt);
    wr_en = 1; wr_idx = 2'(idx); wr_int = isint; wr_vec = vec; wr_ew = 2'(ew);
    wr_key = 5'(key); wr_tgt = 7'(tgt);
  endtask

  task automatic probe(input int p, input bit cmp, input int r, input bit isint);
    c_cmp[p] = cmp; c_reg[p] = 5'(r); c_int[p] = isint;
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    probe(0, 0, 9, 1); probe(1, 0, 0, 0); probe(2, 1, 3, 1);
    step("R1");                                   // empty table after reset
    put(0, 1, 1, 2, 9, 100);
    step("R2");                                   // visible the cycle after the write
    wr_en = 0;
    probe(1, 0, 9, 0);                            // R3 class mismatch misses
    step("R3");
    put(1, 1, 0, 1, 11, 77); probe(2, 1, 3, 1);   // R7 narrow field 3 -> x11
    step("R7");
    wr_en = 0; probe(0, 0, 11, 1); probe(1, 0, 9, 1); probe(2, 0, 9, 0);
    step("R10");                                  // independent ports
    put(2, 1, 1, 3, 9, 5); step("R6");            // x9 still resolves to slot 0
    put(0, 0, 1, 1, 20, 50); step("R6");          // slot 0 retagged: slot 2 now wins
    wr_en = 0; bypass = 1; step("R8");
    bypass = 0; step("R4");
    clr = 1; put(3, 1, 1, 1, 9, 60); step("R9");  // clear beats write
    clr = 0; wr_en = 0; step("R9");

    for (int n = 0; n < 4000; n++) begin
      clr = ($urandom_range(0, 39) == 0);
      wr_en = ($urandom_range(0, 9) < 4);
      wr_idx = 2'($urandom_range(0, 3)); wr_int = 1'($urandom);
      wr_vec = 1'($urandom); wr_ew = 2'($urandom);
      wr_key = 5'($urandom_range(8, 12)); wr_tgt = 7'($urandom);
      bypass = ($urandom_range(0, 9) == 0);
      for (int p = 0; p < 3; p++)
        probe(p, 1'($urandom), $urandom_range(8, 13), 1'($urandom));
      step("");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule